// File: doc/BRIEF.md
# Stack pop-multiple load sequencer

This block carries out one 16-bit pop-multiple instruction. The instruction word holds an 8-bit mask over the low general registers and a separate bit that adds the program counter to the list. The block takes the current stack pointer as the base address. It issues one word read for each selected register through a request/valid memory port and keeps only one read in flight at a time. Registers are filled in ascending order, and the program counter always comes last.

Every returned word first goes into an internal staging buffer. The register file, the stack pointer and the branch are updated only after every read has returned cleanly. A memory fault therefore leaves the architectural state unchanged. The register writes then go out one per cycle. The stack-pointer writeback goes out in the same cycle as the last of them, together with an optional branch request that carries a target and an instruction-set state bit.

Some cases do nothing except raise a flag together with the completion pulse: an empty list, a program-counter load in an illegal position inside a conditional block, and a misaligned stack pointer.

Top module: `popm_seq`

## Requirements
- R1: An instruction word is recognised when bits [15:9] equal 1011110. In that word, bit 8 selects a program-counter load and bits [7:0] select registers 0 to 7. An unrecognised word accepted on `start_i` produces `done_o` in the next cycle with no memory request, no writes and no flags.
- R2: When `cond_pass_i` is low at start, the block raises `done_o` in the next cycle with no memory request, no writes and no flags.
- R3: Reads begin at the stack pointer and step by 4. `mem_req_o` is a one-cycle pulse with a word-aligned address, and no new request is issued until `mem_valid_i` has returned the previous word.
- R4: Selected registers receive data in ascending index order. The lowest selected register receives the word at the stack pointer and each following one the next word. The writes go out one per cycle and only after every read has returned.
- R5: When bit 8 is set, the program-counter word is read last, from the address after the last register word. With `done_o`, `br_valid_o` pulses with `br_target_o` equal to that word with bit 0 cleared and `br_isa_o` equal to its bit 0.
- R6: `sp_we_o` pulses with `done_o`, and `sp_wdata_o` is the starting stack pointer plus 4 times the number of set bits among bit 8 and bits [7:0]. When registers are loaded, this pulse falls in the same cycle as the last register write.
- R7: A stack pointer with bits [1:0] not 00 raises `align_fault_o` with `done_o`, with no reads and no writes.
- R8: A word with bit 8 and bits [7:0] all zero raises `unpred_o` with `done_o`, with no reads and no writes.
- R9: With bit 8 set and `it_mid_i` high, the block raises `unpred_o` with no reads and no writes. With bit 8 clear, `it_mid_i` has no effect.
- R10: A read returned with `mem_fault_i` high ends the sequence with `abort_o` and `done_o`. No register, stack-pointer or branch write follows, and no further reads are issued.
- R11: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. Changes to `start_i`, `instr_i` and `sp_i` while busy have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, accepted when idle |
| instr_i | input | 16 | Instruction word |
| sp_i | input | 32 | Current stack pointer |
| cond_pass_i | input | 1 | Condition passed for this instruction |
| it_mid_i | input | 1 | Inside a conditional block and not its last instruction |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_req_o | output | 1 | Read request pulse |
| mem_addr_o | output | 32 | Read address |
| mem_valid_i | input | 1 | Read data returned |
| mem_rdata_i | input | 32 | Read data |
| mem_fault_i | input | 1 | Returned read faulted |
| rf_we_o | output | 1 | Register-file write enable |
| rf_waddr_o | output | 3 | Register index |
| rf_wdata_o | output | 32 | Register write data |
| sp_we_o | output | 1 | Stack-pointer write enable |
| sp_wdata_o | output | 32 | New stack pointer |
| br_valid_o | output | 1 | Branch request |
| br_target_o | output | 32 | Branch target, bit 0 clear |
| br_isa_o | output | 1 | Instruction-set state taken from bit 0 of the loaded word |
| unpred_o | output | 1 | Unpredictable-case flag, with done |
| align_fault_o | output | 1 | Misaligned stack pointer, with done |
| abort_o | output | 1 | Memory fault, with done |

## Verification
The last register-file write, the stack-pointer writeback and the branch request all fall in one cycle. The bench provokes this by sweeping all 512 combinations of the register mask and the program-counter bit, with memory latencies of one to three cycles. In each cycle it samples `rf_we_o`, `sp_we_o` and `br_valid_o` together. It judges the results against the ascending register order, a stack pointer recomputed from the population count, and a branch target taken from the word that follows the last register word. The empty-list, program-counter-only and full-list patterns bound that overlap from both sides. Fault injection at the first word, a middle word and the program-counter word shows that the overlap never happens once a read faults.

// File: rtl/popm_pkg.sv
package popm_pkg;
  localparam logic [6:0] POPM_OPC = 7'b1011110;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_COMMIT,
    ST_FIN
  } popm_state_e;
endpackage

// File: rtl/popm_decode.sv
module popm_decode
  import popm_pkg::*;
#(
  parameter int unsigned GPR_N = 8,
  localparam int unsigned CW = $clog2(GPR_N + 2)
) (
  input  logic [15:0]      instr_i,
  output logic             match_o,
  output logic             pc_o,
  output logic [GPR_N-1:0] gpr_mask_o,
  output logic [CW-1:0]    words_o
);
  assign match_o    = (instr_i[15:9] == POPM_OPC);
  assign pc_o       = instr_i[8];
  assign gpr_mask_o = instr_i[GPR_N-1:0];

  always_comb begin
    words_o = CW'(pc_o);
    for (int i = 0; i < int'(GPR_N); i++) begin
      words_o = words_o + CW'(gpr_mask_o[i]);
    end
  end
endmodule

// File: rtl/popm_lsb.sv
module popm_lsb #(
  parameter int unsigned N = 8,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o,
  output logic          last_o
);
  assign any_o  = |vec_i;
  // exactly one bit left
  assign last_o = any_o && ((vec_i & (vec_i - N'(1))) == '0);

  always_comb begin
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/popm_buf.sv
module popm_buf #(
  parameter int unsigned DEPTH = 9,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] tail_o
);
  logic [DW-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < int'(DEPTH); g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q[g] <= '0;
      end else if (we_i && (widx_i == IW'(g))) begin
        slot_q[g] <= wdata_i;
      end
    end
  end

  assign rdata_o = (32'(ridx_i) < DEPTH) ? slot_q[ridx_i] : '0;
  assign tail_o  = slot_q[DEPTH-1];
endmodule

// File: rtl/popm_seq.sv
module popm_seq
  import popm_pkg::*;
#(
  parameter int unsigned GPR_N = 8,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 32,
  localparam int unsigned RW   = $clog2(GPR_N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [15:0]   instr_i,
  input  logic [AW-1:0] sp_i,
  input  logic          cond_pass_i,
  input  logic          it_mid_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          mem_req_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_valid_i,
  input  logic [DW-1:0] mem_rdata_i,
  input  logic          mem_fault_i,
  output logic          rf_we_o,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          sp_we_o,
  output logic [AW-1:0] sp_wdata_o,
  output logic          br_valid_o,
  output logic [DW-1:0] br_target_o,
  output logic          br_isa_o,
  output logic          unpred_o,
  output logic          align_fault_o,
  output logic          abort_o
);
  localparam int unsigned SLOTS = GPR_N + 1;
  localparam int unsigned IW    = $clog2(SLOTS);
  localparam int unsigned CW    = $clog2(GPR_N + 2);

  popm_state_e      state_q;
  logic [SLOTS-1:0] rd_mask_q;
  logic [GPR_N-1:0] cm_mask_q;
  logic [AW-1:0]    addr_q, sp_new_q;
  logic             pc_q, unpred_q, align_q, abort_q;

  logic             dec_match, dec_pc;
  logic [GPR_N-1:0] dec_gpr;
  logic [CW-1:0]    dec_words;
  logic             rd_any, rd_last, cm_any, cm_last;
  logic [IW-1:0]    rd_idx;
  logic [RW-1:0]    cm_idx;
  logic [DW-1:0]    cm_data, pc_word;
  logic             accept, bad_list, misal, buf_we, fin_commit;

  popm_decode #(.GPR_N(GPR_N)) u_dec (
    .instr_i    (instr_i),
    .match_o    (dec_match),
    .pc_o       (dec_pc),
    .gpr_mask_o (dec_gpr),
    .words_o    (dec_words)
  );

  popm_lsb #(.N(SLOTS)) u_rd_pick (
    .vec_i  (rd_mask_q),
    .any_o  (rd_any),
    .idx_o  (rd_idx),
    .last_o (rd_last)
  );

  popm_lsb #(.N(GPR_N)) u_cm_pick (
    .vec_i  (cm_mask_q),
    .any_o  (cm_any),
    .idx_o  (cm_idx),
    .last_o (cm_last)
  );

  popm_buf #(.DEPTH(SLOTS), .DW(DW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (buf_we),
    .widx_i  (rd_idx),
    .wdata_i (mem_rdata_i),
    .ridx_i  (IW'(cm_idx)),
    .rdata_o (cm_data),
    .tail_o  (pc_word)
  );

  assign accept   = (state_q == ST_IDLE) && start_i;
  assign bad_list = (dec_words == '0) || (dec_pc && it_mid_i);
  assign misal    = (sp_i[1:0] != 2'b00);
  assign buf_we   = (state_q == ST_WAIT) && mem_valid_i && !mem_fault_i && rd_any;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      rd_mask_q <= '0;
      cm_mask_q <= '0;
      addr_q    <= '0;
      sp_new_q  <= '0;
      pc_q      <= 1'b0;
      unpred_q  <= 1'b0;
      align_q   <= 1'b0;
      abort_q   <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            unpred_q <= 1'b0;
            align_q  <= 1'b0;
            abort_q  <= 1'b0;
            if (!cond_pass_i || !dec_match) begin
              state_q <= ST_FIN;
            end else if (bad_list || misal) begin
              unpred_q <= bad_list;
              align_q  <= misal;
              state_q  <= ST_FIN;
            end else begin
              rd_mask_q <= {dec_pc, dec_gpr};
              cm_mask_q <= dec_gpr;
              addr_q    <= sp_i;
              sp_new_q  <= sp_i + (AW'(dec_words) << 2);
              pc_q      <= dec_pc;
              state_q   <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: begin
          if (mem_valid_i) begin
            if (mem_fault_i) begin
              abort_q <= 1'b1;
              state_q <= ST_FIN;
            end else begin
              rd_mask_q <= rd_mask_q & (rd_mask_q - SLOTS'(1));
              addr_q    <= addr_q + AW'(4);
              state_q   <= rd_last ? ST_COMMIT : ST_ISSUE;
            end
          end
        end
        ST_COMMIT: begin
          cm_mask_q <= cm_mask_q & (cm_mask_q - GPR_N'(1));
          if (fin_commit) state_q <= ST_IDLE;
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fin_commit    = !cm_any || cm_last;
  assign busy_o        = (state_q != ST_IDLE);
  assign mem_req_o     = (state_q == ST_ISSUE);
  assign mem_addr_o    = addr_q;
  assign rf_we_o       = (state_q == ST_COMMIT) && cm_any;
  assign rf_waddr_o    = cm_idx;
  assign rf_wdata_o    = cm_data;
  assign sp_we_o       = (state_q == ST_COMMIT) && fin_commit;
  assign sp_wdata_o    = sp_new_q;
  assign br_valid_o    = sp_we_o && pc_q;
  assign br_target_o   = {pc_word[DW-1:1], 1'b0};
  assign br_isa_o      = pc_word[0];
  assign done_o        = (state_q == ST_FIN) || sp_we_o;
  assign unpred_o      = (state_q == ST_FIN) && unpred_q;
  assign align_fault_o = (state_q == ST_FIN) && align_q;
  assign abort_o       = (state_q == ST_FIN) && abort_q;
endmodule

// File: rtl/popm_seq_chk.sv
module popm_seq_chk #(
  parameter int unsigned DW = 32,
  parameter int unsigned AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          busy_o,
  input logic          done_o,
  input logic          mem_req_o,
  input logic [AW-1:0] mem_addr_o,
  input logic          mem_valid_i,
  input logic          rf_we_o,
  input logic          sp_we_o,
  input logic          br_valid_o,
  input logic [DW-1:0] br_target_o,
  input logic          unpred_o,
  input logic          align_fault_o,
  input logic          abort_o
);
  logic pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          pend_q <= 1'b0;
    else if (mem_req_o)   pend_q <= 1'b1;
    else if (mem_valid_i) pend_q <= 1'b0;
  end

  a_r3_req_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  a_r3_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !pend_q);

  a_r3_word_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  a_r4_commit_after_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> (!pend_q && !mem_req_o));

  a_r6_sp_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> done_o);

  a_r5_branch_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_valid_o |-> (sp_we_o && !br_target_o[0]));

  a_r10_fault_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (unpred_o || align_fault_o || abort_o)) |-> (!rf_we_o && !sp_we_o && !br_valid_o));

  a_r11_done_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);

  a_r11_done_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

bind popm_seq popm_seq_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .mem_req_o     (mem_req_o),
  .mem_addr_o    (mem_addr_o),
  .mem_valid_i   (mem_valid_i),
  .rf_we_o       (rf_we_o),
  .sp_we_o       (sp_we_o),
  .br_valid_o    (br_valid_o),
  .br_target_o   (br_target_o),
  .unpred_o      (unpred_o),
  .align_fault_o (align_fault_o),
  .abort_o       (abort_o)
);

// File: tb/popm_seq_tb.sv
module popm_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] instr_i = '0;
  logic [31:0] sp_i = '0;
  logic        cond_pass_i = 1'b0;
  logic        it_mid_i = 1'b0;
  logic        busy_o, done_o, mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_valid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        mem_fault_i = 1'b0;
  logic        rf_we_o;
  logic [2:0]  rf_waddr_o;
  logic [31:0] rf_wdata_o;
  logic        sp_we_o;
  logic [31:0] sp_wdata_o;
  logic        br_valid_o;
  logic [31:0] br_target_o;
  logic        br_isa_o, unpred_o, align_fault_o, abort_o;

  int nvec = 0;
  int nerr = 0;

  // memory model shared state
  int          lat_g = 1;
  int          flt_g = -1;
  logic [31:0] base_g = '0;
  int          req_cnt = 0;
  int          addr_err = 0;
  int          ovl_err = 0;
  bit          pend = 0;
  int          cd = 0;
  logic [31:0] paddr = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  popm_seq u_dut (
    .clk_i, .rst_ni, .start_i, .instr_i, .sp_i, .cond_pass_i, .it_mid_i,
    .busy_o, .done_o, .mem_req_o, .mem_addr_o, .mem_valid_i, .mem_rdata_i,
    .mem_fault_i, .rf_we_o, .rf_waddr_o, .rf_wdata_o, .sp_we_o, .sp_wdata_o,
    .br_valid_o, .br_target_o, .br_isa_o, .unpred_o, .align_fault_o, .abort_o
  );

  function automatic logic [31:0] memf(input logic [31:0] a);
    return (a * 32'h9E37_79B1) | {31'b0, a[2]};
  endfunction

  function automatic int popc(input logic [8:0] v);
    int n = 0;
    for (int i = 0; i < 9; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int nth_bit(input logic [7:0] l, input int k);
    int seen = 0;
    for (int i = 0; i < 8; i++) begin
      if (l[i]) begin
        if (seen == k) return i;
        seen++;
      end
    end
    return -1;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  always @(negedge clk_i) begin
    mem_valid_i = 1'b0;
    mem_fault_i = 1'b0;
    if (pend) begin
      cd--;
      if (cd == 0) begin
        mem_valid_i = 1'b1;
        mem_rdata_i = memf(paddr);
        mem_fault_i = (req_cnt - 1 == flt_g);
        pend = 0;
      end
    end
    if (mem_req_o) begin
      if (pend) ovl_err++;
      if (mem_addr_o != base_g + 32'(4 * req_cnt)) addr_err++;
      pend = 1;
      cd = lat_g;
      paddr = mem_addr_o;
      req_cnt++;
    end
  end

  task automatic run_op(input logic [15:0] ins, input logic [31:0] sp, input logic cp,
                        input logic itm, input int lat, input int flt, input bit hold);
    logic       match = (ins[15:9] == 7'b1011110);
    logic       pcb   = ins[8];
    logic [7:0] lst   = ins[7:0];
    int         cnt   = popc(ins[8:0]);
    bit         nop   = !cp || !match;
    bit         e_unp = !nop && (cnt == 0 || (pcb && itm));
    bit         e_mis = !nop && (sp[1:0] != 2'b00);
    bit         act   = !nop && !e_unp && !e_mis;
    bit         e_abt = act && (flt >= 0);
    int         e_rd  = !act ? 0 : (e_abt ? flt + 1 : cnt);
    int         e_wr  = (act && !e_abt) ? popc({1'b0, lst}) : 0;
    logic [31:0] pcw  = memf(sp + 32'(4 * popc({1'b0, lst})));
    int         wr_n  = 0;
    int         cyc   = 0;
    bit         fin   = 0;
    lat_g = lat; flt_g = flt; base_g = sp; req_cnt = 0; addr_err = 0; ovl_err = 0;
    @(negedge clk_i);
    start_i = 1'b1; instr_i = ins; sp_i = sp; cond_pass_i = cp; it_mid_i = itm;
    while (!fin && cyc < 400) begin
      @(negedge clk_i);
      cyc++;
      if (!hold) start_i = 1'b0;
      instr_i = ~ins; sp_i = sp ^ 32'h5A5A_0004; cond_pass_i = ~cp; it_mid_i = ~itm;
      chk(busy_o == 1'b1, "R11 busy", 32'(busy_o), 32'd1);
      if (rf_we_o) begin
        chk(32'(rf_waddr_o) == 32'(nth_bit(lst, wr_n)), "R4 order",
            32'(rf_waddr_o), 32'(nth_bit(lst, wr_n)));
        chk(rf_wdata_o == memf(sp + 32'(4 * wr_n)), "R4 data", rf_wdata_o, memf(sp + 32'(4 * wr_n)));
        chk(!mem_req_o, "R4 write after reads", 32'(mem_req_o), 32'd0);
        wr_n++;
      end
      if (done_o) begin
        fin = 1;
        start_i = 1'b0;
        chk(unpred_o == e_unp, "R8 R9 unpred", 32'(unpred_o), 32'(e_unp));
        chk(align_fault_o == e_mis, "R7 align", 32'(align_fault_o), 32'(e_mis));
        chk(abort_o == e_abt, "R10 abort", 32'(abort_o), 32'(e_abt));
        chk(sp_we_o == (act && !e_abt), "R6 sp_we", 32'(sp_we_o), 32'(act && !e_abt));
        if (act && !e_abt) begin
          chk(sp_wdata_o == sp + 32'(4 * cnt), "R6 sp value", sp_wdata_o, sp + 32'(4 * cnt));
          if (e_wr > 0)
            chk(wr_n == e_wr, "R6 last write with sp", 32'(wr_n), 32'(e_wr));
        end
        chk(br_valid_o == (act && !e_abt && pcb), "R5 br_valid", 32'(br_valid_o), 32'(act && !e_abt && pcb));
        if (act && !e_abt && pcb) begin
          chk(br_target_o == {pcw[31:1], 1'b0}, "R5 target", br_target_o, {pcw[31:1], 1'b0});
          chk(br_isa_o == pcw[0], "R5 isa", 32'(br_isa_o), 32'(pcw[0]));
        end
      end
    end
    chk(fin, "R11 done seen", 32'(cyc), 32'd400);
    if (nop || e_unp || e_mis)
      chk(cyc == 1, "R1 R2 one cycle", 32'(cyc), 32'd1);
    chk(wr_n == e_wr, "R4 write count", 32'(wr_n), 32'(e_wr));
    chk(req_cnt == e_rd, "R3 R10 read count", 32'(req_cnt), 32'(e_rd));
    chk(addr_err == 0, "R3 address", 32'(addr_err), 32'd0);
    chk(ovl_err == 0, "R3 one outstanding", 32'(ovl_err), 32'd0);
    @(negedge clk_i);
    chk(!busy_o && !mem_req_o, "R11 idle after done", 32'(busy_o), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    nerr++;
    $display("FAIL R11 watchdog act=expired exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !mem_req_o && !rf_we_o && !sp_we_o, "R11 reset", 32'(busy_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // full sweep: R1 R3 R4 R5 R6 R8 R9
    for (int m = 0; m < 512; m++) begin
      run_op({7'b1011110, 9'(m)}, 32'h2000_0000 + 32'(m * 64), 1'b1,
             (m % 7 == 3), 1 + m % 3, -1, (m % 11 == 5));
    end
    // R2 condition failed
    run_op(16'hBCFF, 32'h1000, 1'b0, 1'b0, 1, -1, 0);
    run_op(16'hBD01, 32'h1004, 1'b0, 1'b0, 2, -1, 0);
    // R1 unrecognised opcodes
    run_op(16'hBEFF, 32'h1000, 1'b1, 1'b0, 1, -1, 0);
    run_op(16'h3CFF, 32'h1000, 1'b1, 1'b0, 1, -1, 0);
    // R7 misaligned, with and without empty list
    for (int a = 1; a < 4; a++) run_op(16'hBC0F, 32'h3000 + 32'(a), 1'b1, 1'b0, 1, -1, 0);
    run_op(16'hBC00, 32'h3002, 1'b1, 1'b0, 1, -1, 0);
    // R9 PC inside block
    run_op(16'hBD81, 32'h4000, 1'b1, 1'b1, 1, -1, 0);
    // R10 faults at first, middle and PC words
    run_op(16'hBCFF, 32'h5000, 1'b1, 1'b0, 2, 0, 0);
    run_op(16'hBDA5, 32'h5100, 1'b1, 1'b0, 1, 2, 0);
    run_op(16'hBD07, 32'h5200, 1'b1, 1'b0, 3, 3, 1);
    // R11 start held throughout
    run_op(16'hBD3C, 32'h6000, 1'b1, 1'b0, 2, -1, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule